// File: doc/BRIEF.md
# Switchable Power Domain Controller

This block sequences four switchable power domains behind a small word-addressed register file. Software asks for a domain to go off or on by writing a control bit. The controller then runs a programmable switch-time counter. Only when that counter has run out does the domain's status bit change. Two counter groups exist: a core group shared by domains 0 to 2, and a separate group for domain 3. Each group has its own power-down count and power-up count.

Each domain also has a bus idle handshake. Software raises a per-domain idle request. The controller answers with an acknowledge once the domain's idle-ready input is high, and it raises an idle indication one cycle later. Releasing the request drops the acknowledge first and the idle indication after it. The intended software order is as follows. To power down, request idle, wait for acknowledge and idle, switch off, then wait for the status bit. To power up, switch on, wait for status, then release the idle request. The switches themselves, clock gating and bus quality-of-service state lie outside the block.

Top module: `pwr_dom_ctrl`

## Requirements
- R1: After reset, all domains read as powered on (status 0) with control 0, idle request 0, idle and acknowledge 0, and all four switch-time counts read 24.
- R2: The control word at byte address 0x08 holds one off-request bit per domain, at bit 7 (domain 0), bit 14 (domain 1), bit 8 (domain 2) and bit 9 (domain 3). A 1 asks for off and a 0 asks for on. Other bits read 0.
- R3: The status word at 0x0C shows each domain at bit 7, 10, 8 and 9 (domains 0 to 3), where 1 means off. After a control write that changes a domain's bit, that status bit changes at the clock edge N+1 cycles after the write edge, where N is the applicable count.
- R4: Counts are written and read at 0x34 (core power-down), 0x38 (core power-up), 0x3C (domain 3 power-down) and 0x40 (domain 3 power-up). Domains 0 to 2 use the core pair and domain 3 uses its own pair. Each count is latched when its transition starts.
- R5: A control write that leaves a domain's bit unchanged starts no transition, so a later change to that bit still takes exactly N+1 cycles.
- R6: A control change that arrives while its domain is mid-transition is held. When the current transition completes, a new transition toward the latest request starts on the next cycle.
- R7: The idle request word at 0x10 uses bit 4, 9, 3 and 2 for domains 0 to 3. In the word at 0x14, each domain's acknowledge sits 16 bits above its request bit. Acknowledge rises one cycle after the request when the domain's idle-ready input is high. It stays low while that input is low.
- R8: Idle status sits in the word at 0x14 at the same position as the request bit, and rises one cycle after acknowledge. When the request is cleared, acknowledge falls one cycle later and idle falls one cycle after that.
- R9: A count of 0 behaves as a count of 1.
- R10: Writes to the status words at 0x0C and 0x14 and to unmapped addresses change nothing. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe, one word per cycle |
| addr_i | input | 8 | Byte address of the word read or written |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| idle_ready_i | input | 4 | Per-domain readiness to enter bus idle |

## Verification
On every cycle, the assertions check the handshake's ordering. An acknowledge may rise only after a qualified request. An acknowledge drops after its request is released. Idle follows the acknowledge in both directions. The assertions also check that a status bit moves only at the end of a running transition, and that every completed transition really moves it. The exact switch latency for each counter group and for a zero count can only be shown by the bench's scenarios. So can the holding of a mid-transition request, the effect of a no-change write, and the read-back of the register map.

// File: rtl/pdc_pkg.sv
package pdc_pkg;
  localparam int NUM_DOM   = 4;
  localparam int NUM_GRP   = 2;
  localparam int CNT_W     = 16;
  localparam int DATA_W    = 32;
  localparam int ADDR_W    = 8;
  localparam int ACK_SHIFT = 16;
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(24);

  localparam logic [ADDR_W-1:0] A_PWR  = 8'h08;
  localparam logic [ADDR_W-1:0] A_STAT = 8'h0C;
  localparam logic [ADDR_W-1:0] A_IREQ = 8'h10;
  localparam logic [ADDR_W-1:0] A_IDLE = 8'h14;
  localparam logic [ADDR_W-1:0] A_CDN  = 8'h34;
  localparam logic [ADDR_W-1:0] A_CUP  = 8'h38;
  localparam logic [ADDR_W-1:0] A_GDN  = 8'h3C;
  localparam logic [ADDR_W-1:0] A_GUP  = 8'h40;

  typedef struct packed {
    logic [CNT_W-1:0] dn;
    logic [CNT_W-1:0] up;
  } cnt_pair_t;

  function automatic int pwr_pos(input int d);
    case (d)
      0: return 7;
      1: return 14;
      2: return 8;
      default: return 9;
    endcase
  endfunction

  function automatic int stat_pos(input int d);
    case (d)
      0: return 7;
      1: return 10;
      2: return 8;
      default: return 9;
    endcase
  endfunction

  function automatic int req_pos(input int d);
    case (d)
      0: return 4;
      1: return 9;
      2: return 3;
      default: return 2;
    endcase
  endfunction

  // domain 3 has its own counter pair, the rest share the core pair
  function automatic int grp_of(input int d);
    return (d == 3) ? 1 : 0;
  endfunction
endpackage

// File: rtl/pdc_pwr_fsm.sv
module pdc_pwr_fsm #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             off_req_i,
  input  logic [CNT_W-1:0] cnt_dn_i,
  input  logic [CNT_W-1:0] cnt_up_i,
  output logic             off_o,
  output logic             busy_o
);
  logic             off_q, busy_q, tgt_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q  <= 1'b0;
      busy_q <= 1'b0;
      tgt_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (off_req_i != off_q) begin
        busy_q <= 1'b1;
        tgt_q  <= off_req_i;
        cnt_q  <= off_req_i ? cnt_dn_i : cnt_up_i;
      end
    end else if (cnt_q <= CNT_W'(1)) begin
      off_q  <= tgt_q;
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign off_o  = off_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/pdc_idle_hs.sv
module pdc_idle_hs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic ready_i,
  output logic ack_o,
  output logic idle_o
);
  logic ack_q, idle_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      idle_q <= 1'b0;
    end else begin
      ack_q  <= req_i & (ack_q | ready_i);
      idle_q <= ack_q;
    end
  end

  assign ack_o  = ack_q;
  assign idle_o = idle_q;
endmodule

// File: rtl/pwr_dom_ctrl.sv
module pwr_dom_ctrl
  import pdc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_DOM-1:0] idle_ready_i
);
  logic [NUM_DOM-1:0] pwr_req_q, ireq_q;
  logic [NUM_DOM-1:0] stat_off, busy, ack, idle;
  cnt_pair_t          cnt_q [NUM_GRP];
  logic [DATA_W-1:0]  w_pwr, w_stat, w_ireq, w_idle;
  logic               unused_wdata;

  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pwr_req_q <= '0;
      ireq_q    <= '0;
      for (int g = 0; g < NUM_GRP; g++) begin
        cnt_q[g].dn <= CNT_RST;
        cnt_q[g].up <= CNT_RST;
      end
    end else if (wr_en_i) begin
      case (addr_i)
        A_PWR:  for (int d = 0; d < NUM_DOM; d++) pwr_req_q[d] <= wdata_i[pwr_pos(d)];
        A_IREQ: for (int d = 0; d < NUM_DOM; d++) ireq_q[d] <= wdata_i[req_pos(d)];
        A_CDN:  cnt_q[0].dn <= wdata_i[CNT_W-1:0];
        A_CUP:  cnt_q[0].up <= wdata_i[CNT_W-1:0];
        A_GDN:  cnt_q[1].dn <= wdata_i[CNT_W-1:0];
        A_GUP:  cnt_q[1].up <= wdata_i[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    localparam int G = grp_of(d);

    pdc_pwr_fsm #(.CNT_W(CNT_W)) u_fsm (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .off_req_i (pwr_req_q[d]),
      .cnt_dn_i  (cnt_q[G].dn),
      .cnt_up_i  (cnt_q[G].up),
      .off_o     (stat_off[d]),
      .busy_o    (busy[d])
    );

    pdc_idle_hs u_hs (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (ireq_q[d]),
      .ready_i (idle_ready_i[d]),
      .ack_o   (ack[d]),
      .idle_o  (idle[d])
    );
  end

  always_comb begin
    w_pwr  = '0;
    w_stat = '0;
    w_ireq = '0;
    w_idle = '0;
    for (int d = 0; d < NUM_DOM; d++) begin
      w_pwr[pwr_pos(d)]            = pwr_req_q[d];
      w_stat[stat_pos(d)]          = stat_off[d];
      w_ireq[req_pos(d)]           = ireq_q[d];
      w_idle[req_pos(d)]           = idle[d];
      w_idle[req_pos(d)+ACK_SHIFT] = ack[d];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_PWR:  rdata_o = w_pwr;
      A_STAT: rdata_o = w_stat;
      A_IREQ: rdata_o = w_ireq;
      A_IDLE: rdata_o = w_idle;
      A_CDN:  rdata_o[CNT_W-1:0] = cnt_q[0].dn;
      A_CUP:  rdata_o[CNT_W-1:0] = cnt_q[0].up;
      A_GDN:  rdata_o[CNT_W-1:0] = cnt_q[1].dn;
      A_GUP:  rdata_o[CNT_W-1:0] = cnt_q[1].up;
      default: ;
    endcase
  end
endmodule

// File: rtl/pdc_checker.sv
module pdc_checker
  import pdc_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_DOM-1:0] req,
  input logic [NUM_DOM-1:0] ready,
  input logic [NUM_DOM-1:0] ack,
  input logic [NUM_DOM-1:0] idle,
  input logic [NUM_DOM-1:0] stat,
  input logic [NUM_DOM-1:0] busy
);
  for (genvar d = 0; d < NUM_DOM; d++) begin : g_chk
    AST_ACK_NEEDS_READY_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(ack[d]) |-> $past(req[d] && ready[d])); // R7
    AST_ACK_DROPS_ON_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni) !req[d] |=> !ack[d]); // R8
    AST_IDLE_RISE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(idle[d]) |-> $past(ack[d])); // R8
    AST_IDLE_FALL_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(idle[d]) |-> !$past(ack[d])); // R8
    AST_STATUS_ONLY_IN_TRANSITION: assert property (@(posedge clk_i) disable iff (!rst_ni) !$stable(stat[d]) |-> $past(busy[d])); // R3
    AST_TRANSITION_MOVES_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni) $fell(busy[d]) |-> !$stable(stat[d])); // R3
  end
endmodule

bind pwr_dom_ctrl pdc_checker u_pdc_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .req    (ireq_q),
  .ready  (idle_ready_i),
  .ack    (ack),
  .idle   (idle),
  .stat   (stat_off),
  .busy   (busy)
);

// File: tb/sim_pwr_dom_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_dom_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  addr_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [3:0]  idle_ready_i = 4'h0;
  int          n_chk = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #10 clk_i = ~clk_i;

  pwr_dom_ctrl u0 (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .rdata_o      (rdata_o),
    .idle_ready_i (idle_ready_i)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // negedges until status bit b reads v
  task automatic meas(input int b, input logic v, output int n);
    logic [31:0] x;
    n = 0;
    for (int i = 0; i < 300; i++) begin
      rd(8'h0C, x);
      if (x[b] == v) return;
      @(negedge clk_i);
      n++;
    end
  endtask

  task automatic t_reset;
    logic [31:0] x;
    rd(8'h08, x); chk("R1 ctrl", x, 32'h0);
    rd(8'h0C, x); chk("R1 status", x, 32'h0);
    rd(8'h10, x); chk("R1 idle req", x, 32'h0);
    rd(8'h14, x); chk("R1 idle/ack", x, 32'h0);
    rd(8'h34, x); chk("R1 core dn", x, 32'd24);
    rd(8'h38, x); chk("R1 core up", x, 32'd24);
    rd(8'h3C, x); chk("R1 d3 dn", x, 32'd24);
    rd(8'h40, x); chk("R1 d3 up", x, 32'd24);
  endtask

  task automatic t_counts;
    logic [31:0] x;
    wr(8'h34, 32'd3); wr(8'h38, 32'd4); wr(8'h3C, 32'd7); wr(8'h40, 32'd5);
    rd(8'h34, x); chk("R4 core dn readback", x, 32'd3);
    rd(8'h38, x); chk("R4 core up readback", x, 32'd4);
    rd(8'h3C, x); chk("R4 d3 dn readback", x, 32'd7);
    rd(8'h40, x); chk("R4 d3 up readback", x, 32'd5);
  endtask

  task automatic t_single_domain;
    logic [31:0] x;
    int n;
    wr(8'h08, 32'h80);
    rd(8'h08, x); chk("R2 ctrl bit7", x, 32'h80);
    meas(7, 1'b1, n); chk("R3 d0 off latency", n, 4);
    rd(8'h0C, x); chk("R3 only d0 off", x, 32'h80);
    wr(8'h08, 32'h0);
    meas(7, 1'b0, n); chk("R3 d0 on latency", n, 5);
  endtask

  task automatic t_all_domains;
    logic [31:0] x;
    int n;
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, x); chk("R2 ctrl mask", x, 32'h4380);
    meas(10, 1'b1, n); chk("R4 d1 core dn", n, 4);
    meas(9, 1'b1, n); chk("R4 d3 own dn", n, 4);
    rd(8'h0C, x); chk("R3 all off", x, 32'h780);
    wr(8'h08, 32'h0);
    meas(8, 1'b0, n); chk("R4 d2 core up", n, 5);
    meas(9, 1'b0, n); chk("R4 d3 own up", n, 1);
  endtask

  task automatic t_no_change;
    int n;
    wr(8'h08, 32'h0);
    wr(8'h08, 32'h80);
    meas(7, 1'b1, n); chk("R5 no spurious transition", n, 4);
    wr(8'h08, 32'h0);
    meas(7, 1'b0, n); chk("R5 restore", n, 5);
  endtask

  task automatic t_held;
    logic [31:0] x;
    int n;
    wr(8'h08, 32'h200);
    wr(8'h08, 32'h0);
    meas(9, 1'b1, n); chk("R6 first transition completes", n, 6);
    rd(8'h08, x); chk("R6 ctrl holds latest", x, 32'h0);
    meas(9, 1'b0, n); chk("R6 held request then runs", n, 6);
  endtask

  task automatic t_idle_wait_ready;
    logic [31:0] x;
    idle_ready_i = 4'h0;
    wr(8'h10, 32'h200);
    rd(8'h10, x); chk("R7 idle req readback", x, 32'h200);
    repeat (3) @(negedge clk_i);
    rd(8'h14, x); chk("R7 no ack while not ready", x, 32'h0);
    idle_ready_i = 4'b0010;
    @(negedge clk_i);
    rd(8'h14, x); chk("R7 ack after ready", x, 32'h0200_0000);
    @(negedge clk_i);
    rd(8'h14, x); chk("R8 idle after ack", x, 32'h0200_0200);
    wr(8'h10, 32'h0);
    rd(8'h14, x); chk("R8 release edge", x, 32'h0200_0200);
    @(negedge clk_i);
    rd(8'h14, x); chk("R8 ack drops first", x, 32'h0000_0200);
    @(negedge clk_i);
    rd(8'h14, x); chk("R8 idle drops next", x, 32'h0);
  endtask

  task automatic t_idle_fast;
    logic [31:0] x;
    idle_ready_i = 4'b0100;
    wr(8'h10, 32'h8);
    rd(8'h14, x); chk("R7 d2 before ack", x, 32'h0);
    @(negedge clk_i);
    rd(8'h14, x); chk("R7 d2 ack one cycle", x, 32'h0008_0000);
    @(negedge clk_i);
    rd(8'h14, x); chk("R8 d2 idle", x, 32'h0008_0008);
  endtask

  task automatic t_zero_count;
    int n;
    wr(8'h34, 32'd0);
    wr(8'h08, 32'h100);
    meas(8, 1'b1, n); chk("R9 zero count acts as one", n, 2);
    wr(8'h08, 32'h0);
    meas(8, 1'b0, n); chk("R9 up count unaffected", n, 5);
  endtask

  task automatic t_readonly;
    logic [31:0] x;
    wr(8'h0C, 32'hFFFF_FFFF);
    repeat (3) @(negedge clk_i);
    rd(8'h0C, x); chk("R10 status write ignored", x, 32'h0);
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, x); chk("R10 idle word write ignored", x, 32'h0008_0008);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, x); chk("R10 unmapped reads zero", x, 32'h0);
    rd(8'h08, x); chk("R10 ctrl untouched", x, 32'h0);
    rd(8'h10, x); chk("R10 idle req untouched", x, 32'h8);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_counts();
    t_single_domain();
    t_all_domains();
    t_no_change();
    t_held();
    t_idle_wait_ready();
    t_idle_fast();
    t_zero_count();
    t_readonly();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule